// File: doc/BRIEF.md
# Bidirectional Pad Boundary-Scan Slice

This block sits between the core and one tri-state bidirectional pad and gives the test controller control of that pad. It holds three scan cells on one serial path. The enable cell has no pad of its own and decides whether the pad is driven. The drive cell supplies the value placed on the pad. The sense cell watches the pad. Each cell has a capture/shift flip-flop and a separate update flip-flop. Values can therefore be scanned in while the pad keeps what it was last given.

When both mode selects are low, the slice is transparent: the core drives the pad and reads it directly. With pad test mode selected, the update stages of the enable and drive cells take over the pad. With core test mode selected, the update stage of the sense cell feeds the core's input. A global float request always turns the pad driver off. Slices join into a longer chain by connecting one slice's `scan_out` to the next slice's `scan_in`.

Top module: `pad_bscan_slice`

## Requirements
- R1: A synchronous active-high `rst` clears all three capture/shift stages and all three update stages. After reset `scan_out` is 0. In pad test mode the pad is then undriven (`pad_oe`=0, `pad_out`=0), and in core test mode `core_in` is 0.
- R2: With `pad_test`=0 and `core_test`=0, `pad_out` equals `core_out`, `pad_oe` equals `core_oe` unless `float_req` is high, and `core_in` equals `pad_in`, all combinationally.
- R3: On a clock edge with `capture_en` high, the enable cell loads `core_oe`, the drive cell loads `core_out` and the sense cell loads `pad_in`.
- R4: On a clock edge with `shift_en` high, bits move one place along the path `scan_in` → enable cell → drive cell → sense cell → `scan_out`. `scan_out` shows the sense cell's capture/shift stage. The first of three shifted bits ends in the sense cell and the third ends in the enable cell.
- R5: Update stages change only on an edge with `update_en` high. Shifting and capturing leave `pad_out`, `pad_oe` and the core-test `core_in` unchanged.
- R6: With `pad_test`=1, `pad_out` equals the drive cell's update stage and `pad_oe` equals the enable cell's update stage, gated by `float_req`.
- R7: With `core_test`=1, `core_in` equals the sense cell's update stage and ignores `pad_in`. The pad side still follows `pad_test`.
- R8: While `float_req` is high, `pad_oe` is 0 in every mode.
- R9: On an edge with `update_en` high, all three update stages load their own capture/shift stage together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high test-logic reset |
| scan_in | input | 1 | Serial data from the previous slice or the chain head |
| scan_out | output | 1 | Serial data to the next slice |
| capture_en | input | 1 | Load parallel inputs into the capture/shift stages |
| shift_en | input | 1 | Shift the chain by one place |
| update_en | input | 1 | Copy the capture/shift stages into the update stages |
| pad_test | input | 1 | Pad side is driven from the update stages |
| core_test | input | 1 | Core input is fed from the sense cell's update stage |
| float_req | input | 1 | Force the pad driver off |
| core_out | input | 1 | Core output data |
| core_oe | input | 1 | Core output enable |
| core_in | output | 1 | Input data presented to the core |
| pad_out | output | 1 | Data to the pad driver |
| pad_oe | output | 1 | Enable of the pad driver |
| pad_in | input | 1 | Value received from the pad |

## Verification
The assertions assume the test controller raises at most one of `capture_en`, `shift_en` and `update_en` in any cycle. One assertion checks this assumption. The bench keeps to it by raising each strobe alone, for exactly the cycles of one capture, one three-bit scan or one update. Mode selects and `float_req` change only between those operations, never while a strobe is high. The cell checks therefore see each stage with a single, clear cause for its next value.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    // Cells on the serial path; index 0 sits next to scan_out.
    localparam int NUM_CELLS = 3;
    localparam int IDX_SENSE = 0;
    localparam int IDX_DRIVE = 1;
    localparam int IDX_ENABLE = NUM_CELLS - 1;

    typedef enum logic [1:0] {
        ROLE_SENSE  = 2'd0,
        ROLE_DRIVE  = 2'd1,
        ROLE_ENABLE = 2'd2
    } cell_role_e;

    typedef struct packed {
        logic data;
        logic enable;
    } pad_drive_t;

    typedef struct packed {
        logic capture;
        logic shift;
        logic update;
    } strobe_t;

    function automatic pad_drive_t gate_float(pad_drive_t d, logic float_req);
        pad_drive_t r;
        r.data   = d.data;
        r.enable = d.enable & ~float_req;
        return r;
    endfunction

endpackage

// File: rtl/bscan_cell.sv
module bscan_cell
    import bscan_pkg::*;
#(
    parameter cell_role_e ROLE = ROLE_SENSE
) (
    input  logic    clk,
    input  logic    rst,
    input  strobe_t strobe,
    input  logic    par_in,
    input  logic    ser_in,
    output logic    sr_q,
    output logic    upd_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= 1'b0;
        end else if (strobe.capture) begin
            sr_q <= par_in;
        end else if (strobe.shift) begin
            sr_q <= ser_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_q <= 1'b0;
        end else if (strobe.update) begin
            upd_q <= sr_q;
        end
    end

    // R3: a capture edge loads the parallel input
    a_r3_capture_loads: assert property (@(posedge clk) disable iff (rst)
        strobe.capture |=> sr_q == $past(par_in));

    // R4: a shift edge (no capture) loads the serial input
    a_r4_shift_loads: assert property (@(posedge clk) disable iff (rst)
        (strobe.shift && !strobe.capture) |=> sr_q == $past(ser_in));

    // R5: the update stage holds without an update strobe
    a_r5_update_holds: assert property (@(posedge clk) disable iff (rst)
        !strobe.update |=> $stable(upd_q));

    // R9: an update edge copies the capture/shift stage
    a_r9_update_copies: assert property (@(posedge clk) disable iff (rst)
        strobe.update |=> upd_q == $past(sr_q));

endmodule

// File: rtl/bscan_pin_mux.sv
module bscan_pin_mux
    import bscan_pkg::*;
(
    input  logic                 pad_test,
    input  logic                 core_test,
    input  logic                 float_req,
    input  logic [NUM_CELLS-1:0] upd_vec,
    input  logic                 core_out,
    input  logic                 core_oe,
    input  logic                 pad_in,
    output pad_drive_t           pad_drv,
    output logic                 core_in
);

    pad_drive_t src;

    always_comb begin
        if (pad_test) begin
            src.data   = upd_vec[IDX_DRIVE];
            src.enable = upd_vec[IDX_ENABLE];
        end else begin
            src.data   = core_out;
            src.enable = core_oe;
        end
        pad_drv = gate_float(src, float_req);
        core_in = core_test ? upd_vec[IDX_SENSE] : pad_in;
    end

endmodule

// File: rtl/pad_bscan_slice.sv
module pad_bscan_slice
    import bscan_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic scan_in,
    output logic scan_out,
    input  logic capture_en,
    input  logic shift_en,
    input  logic update_en,
    input  logic pad_test,
    input  logic core_test,
    input  logic float_req,
    input  logic core_out,
    input  logic core_oe,
    output logic core_in,
    output logic pad_out,
    output logic pad_oe,
    input  logic pad_in
);

    strobe_t              strobe;
    logic [NUM_CELLS-1:0] par_vec;
    logic [NUM_CELLS-1:0] ser_vec;
    logic [NUM_CELLS-1:0] sr_vec;
    logic [NUM_CELLS-1:0] upd_vec;
    pad_drive_t           pad_drv;

    assign strobe = '{capture: capture_en, shift: shift_en, update: update_en};

    always_comb begin
        par_vec             = '0;
        par_vec[IDX_SENSE]  = pad_in;
        par_vec[IDX_DRIVE]  = core_out;
        par_vec[IDX_ENABLE] = core_oe;
    end

    // Serial path runs from the highest index down to index 0.
    genvar gi;
    generate
        for (gi = 0; gi < NUM_CELLS; gi++) begin : g_cell
            if (gi == NUM_CELLS - 1) begin : g_head
                assign ser_vec[gi] = scan_in;
            end else begin : g_link
                assign ser_vec[gi] = sr_vec[gi+1];
            end
            bscan_cell #(
                .ROLE(cell_role_e'(gi))
            ) u_cell (
                .clk    (clk),
                .rst    (rst),
                .strobe (strobe),
                .par_in (par_vec[gi]),
                .ser_in (ser_vec[gi]),
                .sr_q   (sr_vec[gi]),
                .upd_q  (upd_vec[gi])
            );
        end
    endgenerate

    assign scan_out = sr_vec[0];

    bscan_pin_mux u_mux (
        .pad_test  (pad_test),
        .core_test (core_test),
        .float_req (float_req),
        .upd_vec   (upd_vec),
        .core_out  (core_out),
        .core_oe   (core_oe),
        .pad_in    (pad_in),
        .pad_drv   (pad_drv),
        .core_in   (core_in)
    );

    assign pad_out = pad_drv.data;
    assign pad_oe  = pad_drv.enable;

    // Input assumption: at most one strobe per cycle
    a_r4_strobe_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({capture_en, shift_en, update_en}));

    // R2: transparent path in functional mode
    a_r2_transparent: assert property (@(posedge clk) disable iff (rst)
        (!pad_test && !core_test) |-> (core_in == pad_in && pad_out == core_out));

    // R6: pad side follows the update stages in pad test mode
    a_r6_pad_from_update: assert property (@(posedge clk) disable iff (rst)
        (pad_test && !float_req) |->
            (pad_out == upd_vec[IDX_DRIVE] && pad_oe == upd_vec[IDX_ENABLE]));

    // R7: core input follows the sense update stage in core test mode
    a_r7_core_from_update: assert property (@(posedge clk) disable iff (rst)
        core_test |-> core_in == upd_vec[IDX_SENSE]);

    // R8: float request keeps the driver off
    a_r8_float_off: assert property (@(posedge clk) disable iff (rst)
        float_req |-> !pad_oe);

endmodule

// File: tb/pad_bscan_slice_bench.sv
module pad_bscan_slice_bench;

    logic clk = 1'b0;
    logic rst, scan_in, scan_out, capture_en, shift_en, update_en;
    logic pad_test, core_test, float_req, core_out, core_oe, core_in;
    logic pad_out, pad_oe, pad_in;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pad_bscan_slice u_pad_bscan_slice (
        .clk(clk), .rst(rst), .scan_in(scan_in), .scan_out(scan_out),
        .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
        .pad_test(pad_test), .core_test(core_test), .float_req(float_req),
        .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in)
    );

    // {core_out, core_oe, pad_in, float_req, exp pad_out, exp pad_oe, exp core_in}
    localparam logic [6:0] NORMAL_VEC [8] = '{
        7'b1100_110, 7'b0110_011, 7'b1010_101, 7'b0000_000,
        7'b1111_101, 7'b0101_000, 7'b1001_100, 7'b0010_001
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // dout[0] is the first bit out (sense cell), din[0] is the first bit in
    task automatic scan(input logic [2:0] din, output logic [2:0] dout);
        shift_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            dout[i] = scan_out;
            scan_in = din[i];
            tick();
        end
        shift_en = 1'b0;
    endtask

    task automatic do_capture();
        capture_en = 1'b1;
        tick();
        capture_en = 1'b0;
    endtask

    task automatic do_update();
        update_en = 1'b1;
        tick();
        update_en = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [2:0] dout;
        rst = 1'b1; scan_in = 1'b0; capture_en = 1'b0; shift_en = 1'b0;
        update_en = 1'b0; pad_test = 1'b0; core_test = 1'b0; float_req = 1'b0;
        core_out = 1'b1; core_oe = 1'b1; pad_in = 1'b1;
        #1;
        tick(); tick();
        rst = 1'b0;

        // R1: cleared stages after reset
        check("R1 scan_out", {2'b0, scan_out}, 3'b000);
        pad_test = 1'b1; core_test = 1'b1; #1;
        check("R1 pad/core", {pad_out, pad_oe, core_in}, 3'b000);
        pad_test = 1'b0; core_test = 1'b0;

        // R2, R8: transparent table
        for (int k = 0; k < 8; k++) begin
            {core_out, core_oe, pad_in, float_req} = NORMAL_VEC[k][6:3];
            #1;
            check("R2/R8 normal", {pad_out, pad_oe, core_in}, NORMAL_VEC[k][2:0]);
        end
        float_req = 1'b0;

        // R3: capture core_out=1, core_oe=0, pad_in=1
        core_out = 1'b1; core_oe = 1'b0; pad_in = 1'b1;
        do_capture();
        pad_test = 1'b1;
        scan(3'b101, dout);
        check("R3 capture out {enable,drive,sense}", {dout[2], dout[1], dout[0]}, 3'b011);
        // R5: shifting left the reset update stages on the pad
        check("R5 hold during shift", {1'b0, pad_out, pad_oe}, 3'b000);

        // R6, R9: enable=1, drive=0, sense=1
        do_update();
        check("R6/R9 pad after update", {1'b0, pad_out, pad_oe}, 3'b001);
        core_test = 1'b1; pad_in = 1'b0; #1;
        check("R7 core_in from sense", {2'b0, core_in}, 3'b001);

        // R4: previous pattern comes back out in path order
        scan(3'b010, dout);
        check("R4 shift order", dout, 3'b101);
        check("R5 hold during second shift", {1'b0, pad_out, pad_oe}, 3'b001);
        do_update();
        check("R6 pad after second update", {1'b0, pad_out, pad_oe}, 3'b010);
        check("R7 core_in after update", {2'b0, core_in}, 3'b000);

        // R5: capture in pad test mode does not touch the pad
        pad_in = 1'b0; core_out = 1'b1; core_oe = 1'b0;
        do_capture();
        check("R5 hold during capture", {1'b0, pad_out, pad_oe}, 3'b010);
        scan(3'b111, dout);
        check("R3 capture in pad test", {dout[2], dout[1], dout[0]}, 3'b010);
        do_update();
        check("R9 all ones loaded", {pad_out, pad_oe, core_in}, 3'b111);

        // R8: float overrides the enable cell
        float_req = 1'b1; #1;
        check("R8 float in pad test", {2'b0, pad_oe}, 3'b000);
        float_req = 1'b0; #1;
        check("R8 float released", {2'b0, pad_oe}, 3'b001);

        // R7: core test alone, pad side back to core
        pad_test = 1'b0; core_out = 1'b0; core_oe = 1'b0; pad_in = 1'b0; #1;
        check("R7 core test only", {pad_out, pad_oe, core_in}, 3'b001);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule